// File: doc/BRIEF.md
# Fixed-Priority Eight-Level Interrupt Controller

This block gathers up to eight interrupt request lines and tells the processor, through one interrupt output, when one of them needs service. A rising edge on a request line sets a sticky pending bit. Pending bits pass through a software mask and through a fixed priority order, in which level 0 is the most urgent and level 7 the least. They are also blocked by any level that is already in service with equal or higher priority.

The processor answers the interrupt in one of two ways. The first is a two-pulse acknowledge. The first pulse moves the winning level from pending to in-service. The second pulse makes the block emit an 8-bit vector, formed from a 5-bit base on a strap input and the 3-bit level number. The second way, for hosts that have no acknowledge cycle, is to write a poll command to the command port. The next command-port read then returns the winning level and acknowledges it in the same step.

Command-port reads otherwise return the pending register or the in-service register, whichever was selected last. An end-of-interrupt command retires the most urgent in-service level. Data-port accesses write and read the mask. Every access is a one-cycle strobe, and every read result is registered and flagged by a one-cycle valid. There is no back-pressure: the host must take each result in the cycle its valid is high.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on `irq_in[k]`, sampled at the clock, sets pending bit k. The bit stays set after the line falls and is cleared only when level k is acknowledged. A command read with the pending register selected returns the pending bits, with bit k holding level k.
- R2: `int_out` is high exactly when some unmasked pending level is numerically lower than every set in-service level, or when some unmasked pending level exists and no in-service bit is set. Level 0 is the most urgent.
- R3: A data-port write loads the mask from `wdata`, where bit k set masks level k. A masked level neither raises `int_out` nor wins an acknowledge. A data-port read returns the mask.
- R4: On the first `inta` pulse, the in-service bit of the eligible level with the lowest number is set and its pending bit is cleared. Only that one level is acknowledged, even when several are pending.
- R5: On the second `inta` pulse, `vec_out` becomes `{vec_base, level}` and `vec_valid` is high for the single following cycle.
- R6: If no level is eligible at the first `inta` pulse, the vector that follows carries level 7 and the in-service and pending registers are not changed.
- R7: Command byte 0x0C arms a poll. The next command read returns bit 7 = 1 and bits [2:0] = the winning level, and acknowledges that level as R4 does. If no level is eligible, the read returns 0x07 and changes nothing. After the poll read, command reads return the selected register again.
- R8: Command byte 0x0A selects the pending register and 0x0B selects the in-service register for command reads. The selection persists until it is changed.
- R9: Command byte 0x20 clears the lowest-numbered set in-service bit and no other bit.
- R10: After reset the pending, in-service and mask registers are zero, `int_out` is low, and command reads return the pending register.
- R11: A command byte other than 0x0A, 0x0B, 0x0C or 0x20 changes no register, no selection and no output.
- R12: Every read strobe gives `rd_valid` high, with the data on `rd_data`, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines; a rising edge latches a request |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle per pulse, two pulses per acknowledge |
| vec_base | input | 5 | Upper five bits of every vector |
| vec_out | output | 8 | Vector of the acknowledged level |
| vec_valid | output | 1 | One-cycle flag that `vec_out` is new |
| cmd_we | input | 1 | Command-port write strobe |
| cmd_re | input | 1 | Command-port read strobe |
| data_we | input | 1 | Data-port (mask) write strobe |
| data_re | input | 1 | Data-port (mask) read strobe |
| wdata | input | 8 | Write data for either port |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle flag that `rd_data` is new |

## Verification
The bench builds the block with its default parameters: eight levels and an 8-bit data path, which leave a 5-bit vector base. With these values the lowest-priority level, 7, carries the same code as the spurious vector and the empty poll reply. That makes it possible to tell a spurious acknowledge apart from a real level-7 one only through the in-service read. The full width also lets one request pattern of levels 2, 6 and 7 show that the winner is taken from a spread of bits, and lets nested service of levels 1 and 3 show blocking and end-of-interrupt order.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [7:0] CMD_POLL    = 8'h0C;
  localparam logic [7:0] CMD_EOI     = 8'h20;

  typedef enum logic {RSEL_REQ = 1'b0, RSEL_SVC = 1'b1} rsel_e;
endpackage

// File: rtl/pic_first_set.sv
`timescale 1ns/1ps
// Isolates the lowest-numbered set bit (the most urgent level).
module pic_first_set #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [N-1:0] oh
);
  assign oh  = vec & (~vec + {{(N-1){1'b0}}, 1'b1});
  assign any = |vec;
endmodule

// File: rtl/pic_req_latch.sv
`timescale 1ns/1ps
// Edge-triggered, sticky request register.
module pic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_oh,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                       irr[k] <= 1'b0;
      else if (irq_in[k] && !prev_q[k]) irr[k] <= 1'b1;
      else if (clr_oh[k])               irr[k] <= 1'b0;
    end

    // R1
    r1_edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[k] && !prev_q[k]) |=> irr[k]);
  end

  // R4
  r4_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_oh));
endmodule

// File: rtl/pic_svc_track.sv
`timescale 1ns/1ps
// In-service register with retirement of the most urgent level.
module pic_svc_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_oh,
  input  logic         eoi,
  output logic [N-1:0] isr,
  output logic [N-1:0] isr_oh,
  output logic         isr_any
);
  pic_first_set #(.N(N)) u_top (.vec(isr), .any(isr_any), .oh(isr_oh));

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~(eoi ? isr_oh : '0)) | set_oh;
  end

  // R4
  r4_svc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_oh && !eoi) |=> $countones(isr) == $countones($past(isr)) + 1);

  // R9
  r9_eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_any && !(|set_oh)) |=> $countones(isr) + 1 == $countones($past(isr)));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LVL_W  = $clog2(N),
  localparam int BASE_W = DW - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  output logic              int_out,
  input  logic              inta,
  input  logic [BASE_W-1:0] vec_base,
  output logic [DW-1:0]     vec_out,
  output logic              vec_valid,
  input  logic              cmd_we,
  input  logic              cmd_re,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  logic [N-1:0]     irr, isr, isr_oh, mask_q;
  logic             isr_any;
  logic [N-1:0]     below, elig, win_oh, take_oh;
  logic             win_any;
  logic [LVL_W-1:0] win_idx, lvl_q;
  logic             phase_q, spur_q, poll_q;
  rsel_e            rsel_q;
  logic             eoi, poll_rd, ack_take;
  logic [DW-1:0]    poll_byte;

  assign eoi      = cmd_we && (wdata == CMD_EOI);
  assign poll_rd  = cmd_re && poll_q;
  assign ack_take = (inta && !phase_q) || poll_rd;
  assign take_oh  = ack_take ? win_oh : '0;

  pic_req_latch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_oh(take_oh), .irr(irr)
  );

  pic_svc_track #(.N(N)) u_svc (
    .clk(clk), .rst_n(rst_n), .set_oh(take_oh), .eoi(eoi),
    .isr(isr), .isr_oh(isr_oh), .isr_any(isr_any)
  );

  // Only levels more urgent than the top in-service level may compete.
  assign below = isr_any ? (isr_oh - {{(N-1){1'b0}}, 1'b1}) : '1;
  assign elig  = irr & ~mask_q & below;

  pic_first_set #(.N(N)) u_win (.vec(elig), .any(win_any), .oh(win_oh));

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++)
      if (win_oh[i]) win_idx = LVL_W'(i);
  end

  assign int_out = win_any;

  always_comb begin
    poll_byte = '0;
    poll_byte[DW-1] = win_any;
    poll_byte[LVL_W-1:0] = win_any ? win_idx : '1;
  end

  // Acknowledge sequencer: first pulse resolves, second emits the vector.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      spur_q    <= 1'b0;
      lvl_q     <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= 1'b0;
      if (inta && !phase_q) begin
        phase_q <= 1'b1;
        spur_q  <= !win_any;
        lvl_q   <= win_any ? win_idx : '1;
      end else if (inta && phase_q) begin
        phase_q   <= 1'b0;
        vec_out   <= {vec_base, lvl_q};
        vec_valid <= 1'b1;
      end
    end
  end

  // Command decode and register access.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      rsel_q   <= RSEL_REQ;
      poll_q   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (data_we) mask_q <= wdata[N-1:0];
      if (poll_rd) poll_q <= 1'b0;
      if (cmd_we) begin
        case (wdata)
          CMD_SEL_REQ: rsel_q <= RSEL_REQ;
          CMD_SEL_SVC: rsel_q <= RSEL_SVC;
          CMD_POLL:    poll_q <= 1'b1;
          default:     ;
        endcase
      end
      rd_valid <= cmd_re || data_re;
      if (cmd_re) begin
        if (poll_q)                  rd_data <= poll_byte;
        else if (rsel_q == RSEL_SVC) rd_data <= DW'(isr);
        else                         rd_data <= DW'(irr);
      end else if (data_re) begin
        rd_data <= DW'(mask_q);
      end
    end
  end

  // R2
  r2_block_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (!isr_any || (win_oh < isr_oh)));

  // R5
  r5_vec_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  // R6
  r6_spur_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !phase_q && !win_any && !eoi && !poll_rd) |=> $stable(isr));

  // R6
  r6_spur_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && phase_q && spur_q) |=> (vec_out[LVL_W-1:0] == '1));

  // R12
  r12_rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_re || data_re) |=> rd_valid);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta = 1'b0;
  logic [4:0] vec_base = 5'h11;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic       cmd_we = 1'b0, cmd_re = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vec_base(vec_base), .vec_out(vec_out), .vec_valid(vec_valid),
    .cmd_we(cmd_we), .cmd_re(cmd_re), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    @(negedge clk); cmd_we = 1'b1; wdata = v;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_mask(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic rd_cmd(output logic [7:0] v);
    @(negedge clk); cmd_re = 1'b1;
    @(negedge clk); cmd_re = 1'b0;
    chk("R12 cmd rd_valid", {7'b0, rd_valid}, 8'h01);
    v = rd_data;
  endtask

  task automatic rd_mask(output logic [7:0] v);
    @(negedge clk); data_re = 1'b1;
    @(negedge clk); data_re = 1'b0;
    chk("R12 data rd_valid", {7'b0, rd_valid}, 8'h01);
    v = rd_data;
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack_pair(input string req, input logic [7:0] exp_vec);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    chk({req, " vec_valid"}, {7'b0, vec_valid}, 8'h01);
    chk({req, " vec_out"}, vec_out, exp_vec);
    @(negedge clk);
    chk("R5 vec_valid one cycle", {7'b0, vec_valid}, 8'h00);
  endtask

  task automatic rd_svc(input string req, input logic [7:0] exp);
    logic [7:0] v;
    wr_cmd(8'h0B); rd_cmd(v); chk(req, v, exp);
  endtask

  task automatic rd_req(input string req, input logic [7:0] exp);
    logic [7:0] v;
    wr_cmd(8'h0A); rd_cmd(v); chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R10 int_out", {7'b0, int_out}, 8'h00);
    rd_cmd(v); chk("R10 default select pending", v, 8'h00);
    rd_mask(v); chk("R10 mask", v, 8'h00);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    pulse_irq(8'h28);
    chk("R2 int_out on pending", {7'b0, int_out}, 8'h01);
    @(negedge clk);
    rd_cmd(v); chk("R1 sticky pending", v, 8'h28);
  endtask

  task automatic t_ack;
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    chk("R2 lower level blocked by service", {7'b0, int_out}, 8'h00);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    chk("R5 vec_valid", {7'b0, vec_valid}, 8'h01);
    chk("R5 vector level 3", vec_out, 8'h8B);
    rd_svc("R4 service bit set", 8'h08);
    rd_req("R4 pending bit cleared", 8'h20);
  endtask

  task automatic t_nest;
    pulse_irq(8'h02);
    chk("R2 more urgent level passes", {7'b0, int_out}, 8'h01);
    ack_pair("R5 nested", 8'h89);
    rd_svc("R4 nested service", 8'h0A);
    wr_cmd(8'h20);
    rd_svc("R9 eoi clears most urgent", 8'h08);
    wr_cmd(8'h20);
    rd_svc("R9 second eoi", 8'h00);
    chk("R2 released after eoi", {7'b0, int_out}, 8'h01);
  endtask

  task automatic t_mask_spur;
    logic [7:0] v;
    wr_mask(8'h20);
    chk("R3 masked level silent", {7'b0, int_out}, 8'h00);
    rd_mask(v); chk("R3 mask readback", v, 8'h20);
    ack_pair("R6 spurious", 8'h8F);
    rd_svc("R6 no service bit", 8'h00);
    rd_req("R6 pending kept", 8'h20);
  endtask

  task automatic t_poll;
    logic [7:0] v;
    wr_mask(8'h00);
    wr_cmd(8'h0C);
    rd_cmd(v); chk("R7 poll reply", v, 8'h85);
    rd_cmd(v); chk("R7 back to pending select", v, 8'h00);
    rd_svc("R7 poll acknowledged", 8'h20);
    wr_cmd(8'h0C);
    rd_cmd(v); chk("R7 empty poll", v, 8'h07);
    rd_cmd(v); chk("R8 select persists", v, 8'h20);
    wr_cmd(8'h20);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    pulse_irq(8'h10);
    wr_cmd(8'h0B);
    wr_cmd(8'h55);
    chk("R11 int_out unchanged", {7'b0, int_out}, 8'h01);
    rd_cmd(v); chk("R11 select unchanged", v, 8'h00);
    rd_req("R11 pending unchanged", 8'h10);
    ack_pair("R5 level 4", 8'h8C);
    wr_cmd(8'h20);
  endtask

  task automatic t_prio;
    pulse_irq(8'hC4);
    ack_pair("R4 winner level 2", 8'h8A);
    rd_svc("R4 only level 2 served", 8'h04);
    rd_req("R1 others still pending", 8'hC0);
  endtask

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_ack();
    t_nest();
    t_mask_spur();
    t_poll();
    t_ignore();
    t_prio();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule